// File: doc/BRIEF.md
# Endpoint Ping-Pong Handshake Controller

This block decides how a device answers each host token aimed at one of its eight endpoints. It keeps one 32-bit configuration word per endpoint and a ready mask with one bit per buffer. Each user endpoint (1 to 7) owns two buffers that alternate. Endpoint 0 owns a single buffer that serves both directions. For each request the block returns the handshake to send, the buffer it picked and that buffer's base word address. When a transfer completes, it also returns pulses that report the consumed buffer and the changes to the data toggle and the buffer select.

Firmware loads the configuration words through a write port and reads them back through a read port. It marks buffers ready by pulsing a set mask. The packet engine presents one request per cycle (token, endpoint, received data PID, receive-success flag). The response appears one cycle later. The block applies its own updates to the ready mask and to the configuration words at the same clock edge.

Configuration word fields: bit 31 enable, bit 30 stall, bit 29 direction (1 = IN to host), bit 28 isochronous, bit 27 data toggle (1 = DATA1), bit 26 buffer select (1 = second buffer). Bits 21:11 hold the packet size in bytes and bits 10:0 hold the base word address. Ready bit e + 8*b belongs to buffer b of endpoint e. Endpoint 0 uses bit 0 only, and bit 8 does not exist.

Top module: `ep_hs_ctrl`

## Requirements
- R1: Token codes are 0 OUT, 1 IN, 2 SETUP. A request with reserved token 3, or one aimed at an endpoint whose enable bit 31 is clear, gets response code 0 (none) and changes no state. Response codes are 0 none, 1 ACK, 2 NAK, 3 STALL, 4 data sent.
- R2: On an enabled endpoint with stall bit 30 set, every request that is not a failed OUT/SETUP reception gets STALL, and no state changes.
- R3: A request to a non-isochronous endpoint whose selected buffer's ready bit is clear gets NAK. For an isochronous endpoint the same case gets none. In both cases no state changes.
- R4: A successful non-isochronous OUT with matching data PID gets ACK. A successful IN acknowledged by the host gets data sent. Either one clears the used ready bit, flips the toggle, flips the buffer select (endpoints 1-7 only), pulses the matching done_o bit, and raises tog_flip_o and bsel_flip_o as applicable.
- R5: A non-isochronous OUT whose data PID differs from the stored toggle gets ACK, and the ready mask, toggle and buffer select stay unchanged.
- R6: An OUT or SETUP received with an error gets none and changes nothing. An IN that the host does not acknowledge gets data sent and changes nothing.
- R7: Endpoint 0 always uses buffer 0 and ready bit 0, and accepts all three tokens. A ready SETUP gets ACK regardless of the data PID, sets the toggle to 1, and never changes the buffer select.
- R8: On endpoints 1-7, a SETUP token, or an IN/OUT token that disagrees with direction bit 29, gets STALL and changes nothing.
- R9: The buffer 0 address is the base field. The buffer 1 address is base + ceil(size/4) modulo 2^11, where size is clamped to 512 bytes (non-isochronous) or 1024 bytes (isochronous).
- R10: On an isochronous endpoint with a ready buffer, the request consumes the buffer (clears the ready bit, flips the buffer select, pulses done_o) without touching the toggle. IN gets data sent, OUT gets none, and ACK/NAK are never returned.
- R11: Every request is answered exactly one cycle later with rsp_valid_o high. rsp_valid_o is low in cycles that follow no request.
- R12: A firmware configuration write overrides a same-cycle update to that endpoint's word. A ready-set bit wins over a same-cycle clear. Ready bit 8 always reads 0. After reset all words and the mask read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Transaction request present |
| req_tok_i | input | 2 | Token: 0 OUT, 1 IN, 2 SETUP, 3 reserved |
| req_ep_i | input | 3 | Target endpoint |
| req_pid_i | input | 1 | Received data PID (1 = DATA1) |
| req_rx_ok_i | input | 1 | OUT/SETUP: packet received clean; IN: host acknowledged |
| cfg_we_i | input | 1 | Configuration word write strobe |
| cfg_ep_i | input | 3 | Endpoint written |
| cfg_wdata_i | input | 32 | Configuration word written |
| rdy_set_i | input | 16 | Ready bits to set |
| cfg_rd_ep_i | input | 3 | Endpoint read back |
| cfg_rd_data_o | output | 32 | Configuration word of cfg_rd_ep_i |
| rdy_o | output | 16 | Current ready mask |
| rsp_valid_o | output | 1 | Response present |
| rsp_code_o | output | 3 | Handshake code |
| rsp_buf_o | output | 1 | Buffer index used |
| rsp_addr_o | output | 11 | Base word address of that buffer |
| done_o | output | 16 | One-hot buffer-complete pulse (ready bit index) |
| tog_flip_o | output | 1 | Data toggle changed |
| bsel_flip_o | output | 1 | Buffer select changed |

## Verification
A stuck or lost toggle first shows up as a wrongly discarded OUT packet: an ACK with no done_o pulse on the next matching request to that endpoint. It also shows at once in the word read back. A buffer select that fails to alternate shows in the very next response to that endpoint, through rsp_buf_o and rsp_addr_o pointing at the same buffer twice. A ready bit that is not cleared, or is cleared in the wrong place, shows in rdy_o one cycle after the commit. It later shows as an ACK where a NAK was due.

// File: rtl/ep_hs_pkg.sv
package ep_hs_pkg;
  typedef enum logic [1:0] {
    TOK_OUT = 2'd0, TOK_IN = 2'd1, TOK_SETUP = 2'd2, TOK_RSVD = 2'd3
  } tok_e;

  typedef enum logic [2:0] {
    HS_NONE = 3'd0, HS_ACK = 3'd1, HS_NAK = 3'd2, HS_STALL = 3'd3, HS_DATA = 3'd4
  } hs_e;

  // flag vector = cfg[31:26]
  localparam int unsigned F_EN    = 5;
  localparam int unsigned F_STALL = 4;
  localparam int unsigned F_DIR   = 3;
  localparam int unsigned F_ISO   = 2;
  localparam int unsigned F_TOG   = 1;
  localparam int unsigned F_BSEL  = 0;
  localparam int unsigned FLAG_LSB = 26;
  localparam int unsigned B_TOG   = FLAG_LSB + F_TOG;
  localparam int unsigned B_BSEL  = FLAG_LSB + F_BSEL;
endpackage

// File: rtl/ep_hs_decide.sv
module ep_hs_decide
  import ep_hs_pkg::*;
#(
  parameter int unsigned NUM_EP = 8,
  localparam int unsigned EP_W   = $clog2(NUM_EP),
  localparam int unsigned RIDX_W = EP_W + 1,
  localparam int unsigned RDY_W  = 2 * NUM_EP
) (
  input  logic              valid_i,
  input  logic [1:0]        tok_i,
  input  logic [EP_W-1:0]   ep_i,
  input  logic              pid_i,
  input  logic              rx_ok_i,
  input  logic [5:0]        flags_i,
  input  logic [RDY_W-1:0]  rdy_i,
  output hs_e               code_o,
  output logic              commit_o,
  output logic              tflip_o,
  output logic              bflip_o,
  output logic              buf_o,
  output logic [RIDX_W-1:0] ridx_o
);
  logic is_ep0, is_in, is_out, is_setup, rdy_ok, dir_bad;

  always_comb begin
    is_ep0   = (ep_i == '0);
    is_in    = (tok_i == TOK_IN);
    is_out   = (tok_i == TOK_OUT);
    is_setup = (tok_i == TOK_SETUP);
    buf_o    = is_ep0 ? 1'b0 : flags_i[F_BSEL];
    ridx_o   = {buf_o, ep_i};
    rdy_ok   = rdy_i[ridx_o];
    dir_bad  = !is_ep0 && (is_setup || (is_in != flags_i[F_DIR]));

    code_o   = HS_NONE;
    commit_o = 1'b0;
    tflip_o  = 1'b0;
    bflip_o  = 1'b0;

    if (!valid_i || tok_i == TOK_RSVD || !flags_i[F_EN]) begin
      code_o = HS_NONE;
    end else if (!is_in && !rx_ok_i) begin
      code_o = HS_NONE;
    end else if (flags_i[F_STALL] || dir_bad) begin
      code_o = HS_STALL;
    end else if (!rdy_ok) begin
      code_o = flags_i[F_ISO] ? HS_NONE : HS_NAK;
    end else if (flags_i[F_ISO]) begin
      code_o   = is_in ? HS_DATA : HS_NONE;
      commit_o = 1'b1;
      bflip_o  = !is_ep0;
    end else if (is_setup) begin
      code_o   = HS_ACK;
      commit_o = 1'b1;
      tflip_o  = !flags_i[F_TOG];
    end else if (is_out) begin
      code_o = HS_ACK;
      if (pid_i == flags_i[F_TOG]) begin
        commit_o = 1'b1;
        tflip_o  = 1'b1;
        bflip_o  = !is_ep0;
      end
    end else begin
      code_o = HS_DATA;
      if (rx_ok_i) begin
        commit_o = 1'b1;
        tflip_o  = 1'b1;
        bflip_o  = !is_ep0;
      end
    end
  end
endmodule

// File: rtl/ep_hs_addr.sv
module ep_hs_addr #(
  parameter int unsigned ADDR_W  = 11,
  parameter int unsigned SIZE_W  = 11,
  parameter int unsigned MAX_PKT = 512,
  parameter int unsigned MAX_ISO = 1024,
  localparam int unsigned EW     = SIZE_W + 2
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              iso_i,
  input  logic              buf_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [EW-1:0] lim, sz, eff, words;

  always_comb begin
    lim    = iso_i ? EW'(MAX_ISO) : EW'(MAX_PKT);
    sz     = {2'b00, size_i};
    eff    = (sz > lim) ? lim : sz;
    words  = (eff + EW'(3)) >> 2;
    addr_o = base_i + (buf_i ? ADDR_W'(words) : '0);
  end
endmodule

// File: rtl/ep_hs_regs.sv
module ep_hs_regs
  import ep_hs_pkg::*;
#(
  parameter int unsigned NUM_EP = 8,
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned SIZE_W = 11,
  localparam int unsigned EP_W   = $clog2(NUM_EP),
  localparam int unsigned RIDX_W = EP_W + 1,
  localparam int unsigned RDY_W  = 2 * NUM_EP
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [EP_W-1:0]   cfg_ep_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic [RDY_W-1:0]  rdy_set_i,
  input  logic [EP_W-1:0]   upd_ep_i,
  input  logic              commit_i,
  input  logic              tflip_i,
  input  logic              bflip_i,
  input  logic [RIDX_W-1:0] ridx_i,
  input  logic [EP_W-1:0]   rd_ep_i,
  output logic [31:0]       rd_data_o,
  output logic [5:0]        upd_flags_o,
  output logic [ADDR_W-1:0] upd_base_o,
  output logic [SIZE_W-1:0] upd_size_o,
  output logic [RDY_W-1:0]  rdy_o
);
  localparam logic [RDY_W-1:0] RDY_MASK = ~(RDY_W'(1) << NUM_EP);

  logic [31:0]      cfg_q [NUM_EP];
  logic [RDY_W-1:0] rdy_q, clr_vec;
  logic [31:0]      upd_word;

  assign clr_vec = commit_i ? (RDY_W'(1) << ridx_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_q <= '0;
    else         rdy_q <= ((rdy_q & ~clr_vec) | rdy_set_i) & RDY_MASK;
  end

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[e] <= '0;
      end else if (cfg_we_i && cfg_ep_i == EP_W'(e)) begin
        cfg_q[e] <= cfg_wdata_i;
      end else if (commit_i && upd_ep_i == EP_W'(e)) begin
        cfg_q[e][B_TOG]  <= cfg_q[e][B_TOG] ^ tflip_i;
        cfg_q[e][B_BSEL] <= cfg_q[e][B_BSEL] ^ bflip_i;
      end
    end
  end

  always_comb begin
    upd_word    = cfg_q[upd_ep_i];
    upd_flags_o = upd_word[31:26];
    upd_base_o  = upd_word[ADDR_W-1:0];
    upd_size_o  = upd_word[ADDR_W +: SIZE_W];
    rd_data_o   = cfg_q[rd_ep_i];
    rdy_o       = rdy_q;
  end

  p_no_bit8_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_q[NUM_EP] == 1'b0);

  p_cfg_write_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> cfg_q[$past(cfg_ep_i)] == $past(cfg_wdata_i));

  for (genvar i = 0; i < RDY_W; i++) begin : g_chk
    p_clear_used_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_vec[i] && !rdy_set_i[i]) |=> !rdy_q[i]);
  end
endmodule

// File: rtl/ep_hs_ctrl.sv
module ep_hs_ctrl
  import ep_hs_pkg::*;
#(
  parameter int unsigned NUM_EP  = 8,
  parameter int unsigned ADDR_W  = 11,
  parameter int unsigned SIZE_W  = 11,
  parameter int unsigned MAX_PKT = 512,
  parameter int unsigned MAX_ISO = 1024,
  localparam int unsigned EP_W   = $clog2(NUM_EP),
  localparam int unsigned RIDX_W = EP_W + 1,
  localparam int unsigned RDY_W  = 2 * NUM_EP
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_tok_i,
  input  logic [EP_W-1:0]   req_ep_i,
  input  logic              req_pid_i,
  input  logic              req_rx_ok_i,
  input  logic              cfg_we_i,
  input  logic [EP_W-1:0]   cfg_ep_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic [RDY_W-1:0]  rdy_set_i,
  input  logic [EP_W-1:0]   cfg_rd_ep_i,
  output logic [31:0]       cfg_rd_data_o,
  output logic [RDY_W-1:0]  rdy_o,
  output logic              rsp_valid_o,
  output logic [2:0]        rsp_code_o,
  output logic              rsp_buf_o,
  output logic [ADDR_W-1:0] rsp_addr_o,
  output logic [RDY_W-1:0]  done_o,
  output logic              tog_flip_o,
  output logic              bsel_flip_o
);
  logic [5:0]        flags;
  logic [ADDR_W-1:0] base, addr;
  logic [SIZE_W-1:0] size;
  hs_e               code;
  logic              commit, tflip, bflip, buf_sel;
  logic [RIDX_W-1:0] ridx;

  ep_hs_regs #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) i_regs (
    .clk_i, .rst_ni,
    .cfg_we_i, .cfg_ep_i, .cfg_wdata_i, .rdy_set_i,
    .upd_ep_i(req_ep_i), .commit_i(commit), .tflip_i(tflip), .bflip_i(bflip),
    .ridx_i(ridx), .rd_ep_i(cfg_rd_ep_i), .rd_data_o(cfg_rd_data_o),
    .upd_flags_o(flags), .upd_base_o(base), .upd_size_o(size), .rdy_o(rdy_o)
  );

  ep_hs_decide #(.NUM_EP(NUM_EP)) i_decide (
    .valid_i(req_valid_i), .tok_i(req_tok_i), .ep_i(req_ep_i),
    .pid_i(req_pid_i), .rx_ok_i(req_rx_ok_i), .flags_i(flags), .rdy_i(rdy_o),
    .code_o(code), .commit_o(commit), .tflip_o(tflip), .bflip_o(bflip),
    .buf_o(buf_sel), .ridx_o(ridx)
  );

  ep_hs_addr #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .MAX_PKT(MAX_PKT),
               .MAX_ISO(MAX_ISO)) i_addr (
    .base_i(base), .size_i(size), .iso_i(flags[F_ISO]), .buf_i(buf_sel),
    .addr_o(addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_code_o  <= HS_NONE;
      rsp_buf_o   <= 1'b0;
      rsp_addr_o  <= '0;
      done_o      <= '0;
      tog_flip_o  <= 1'b0;
      bsel_flip_o <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_code_o  <= code;
      rsp_buf_o   <= buf_sel;
      rsp_addr_o  <= addr;
      done_o      <= commit ? (RDY_W'(1) << ridx) : '0;
      tog_flip_o  <= commit & tflip;
      bsel_flip_o <= commit & bflip;
    end
  end

  p_answer_next_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  p_disabled_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !flags[F_EN]) |=> (rsp_code_o == HS_NONE && done_o == '0));

  p_stall_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && flags[F_EN] && flags[F_STALL] && req_tok_i != TOK_RSVD &&
     (req_tok_i == TOK_IN || req_rx_ok_i)) |=> (rsp_code_o == HS_STALL && done_o == '0));

  p_nak_no_change_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_code_o == HS_NAK) |-> (done_o == '0 && !tog_flip_o && !bsel_flip_o));

  p_done_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done_o));

  p_iso_no_hs_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && flags[F_ISO]) |=>
      (rsp_code_o != HS_ACK && rsp_code_o != HS_NAK && !tog_flip_o));
endmodule

// File: tb/test_ep_hs_ctrl.sv
module test_ep_hs_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int C_NONE = 0, C_ACK = 1, C_NAK = 2, C_STALL = 3, C_DATA = 4;
  localparam int T_OUT = 0, T_IN = 1, T_SETUP = 2;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        req_valid = 0, req_pid = 0, req_ok = 0, cfg_we = 0;
  logic [1:0]  req_tok = 0;
  logic [2:0]  req_ep = 0, cfg_ep = 0, rd_ep = 0;
  logic [31:0] cfg_wdata = 0, rd_data;
  logic [15:0] rdy_set = 0, rdy, done;
  logic        rsp_valid, rsp_buf, tog_flip, bsel_flip;
  logic [2:0]  rsp_code;
  logic [10:0] rsp_addr;

  int n_chk = 0, n_err = 0;

  logic [31:0] m_cfg [8];
  logic [15:0] m_rdy;
  int e_code, e_buf, e_addr, e_done, e_tf, e_bf;
  string e_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep_hs_ctrl i_ep_hs_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_tok_i(req_tok), .req_ep_i(req_ep),
    .req_pid_i(req_pid), .req_rx_ok_i(req_ok),
    .cfg_we_i(cfg_we), .cfg_ep_i(cfg_ep), .cfg_wdata_i(cfg_wdata),
    .rdy_set_i(rdy_set), .cfg_rd_ep_i(rd_ep), .cfg_rd_data_o(rd_data),
    .rdy_o(rdy), .rsp_valid_o(rsp_valid), .rsp_code_o(rsp_code),
    .rsp_buf_o(rsp_buf), .rsp_addr_o(rsp_addr), .done_o(done),
    .tog_flip_o(tog_flip), .bsel_flip_o(bsel_flip)
  );

  task automatic chk(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(bit en, bit st, bit dir, bit iso, bit tog,
                                     bit bs, int size, int base);
    return {en, st, dir, iso, tog, bs, 4'b0, size[10:0], base[10:0]};
  endfunction

  function automatic int f_addr(logic [31:0] c, int b);
    int lim, sz, eff;
    lim = c[28] ? 1024 : 512;
    sz  = int'(c[21:11]);
    eff = (sz > lim) ? lim : sz;
    return (int'(c[10:0]) + (b != 0 ? (eff + 3) / 4 : 0)) & 'h7ff;
  endfunction

  task automatic predict(bit v, int tk, int ep, bit pid, bit ok);
    logic [31:0] c;
    bit e0, rd, commit;
    int b, ri;
    c = m_cfg[ep]; e0 = (ep == 0);
    b = e0 ? 0 : int'(c[26]); ri = ep + 8 * b; rd = m_rdy[ri];
    e_code = C_NONE; e_buf = b; e_addr = f_addr(c, b);
    e_done = 0; e_tf = 0; e_bf = 0; e_tag = "R11"; commit = 0;
    if (!v) return;
    if (tk == 3 || !c[31]) e_tag = "R1";
    else if (tk != T_IN && !ok) e_tag = "R6";
    else if (c[30]) begin e_code = C_STALL; e_tag = "R2"; end
    else if (!e0 && (tk == T_SETUP || ((tk == T_IN) != c[29]))) begin
      e_code = C_STALL; e_tag = "R8";
    end else if (!rd) begin e_code = c[28] ? C_NONE : C_NAK; e_tag = "R3"; end
    else if (c[28]) begin
      e_code = (tk == T_IN) ? C_DATA : C_NONE; commit = 1; e_bf = !e0; e_tag = "R10";
    end else if (tk == T_SETUP) begin
      e_code = C_ACK; commit = 1; e_tf = !c[27]; e_tag = "R7";
    end else if (tk == T_OUT && pid != c[27]) begin e_code = C_ACK; e_tag = "R5"; end
    else if (tk == T_OUT) begin
      e_code = C_ACK; commit = 1; e_tf = 1; e_bf = !e0; e_tag = e0 ? "R7" : "R4";
    end else begin
      e_code = C_DATA; e_tag = ok ? "R4" : "R6";
      if (ok) begin commit = 1; e_tf = 1; e_bf = !e0; end
    end
    if (commit) begin
      e_done = 1 << ri; m_rdy[ri] = 1'b0;
      m_cfg[ep][27] = m_cfg[ep][27] ^ e_tf[0];
      m_cfg[ep][26] = m_cfg[ep][26] ^ e_bf[0];
    end
  endtask

  // one cycle: drive, predict, check after the edge
  task automatic step(bit v, int tk, int ep, bit pid, bit ok,
                      bit we, int wep, logic [31:0] wd, logic [15:0] set);
    req_valid = v; req_tok = tk[1:0]; req_ep = ep[2:0]; req_pid = pid; req_ok = ok;
    cfg_we = we; cfg_ep = wep[2:0]; cfg_wdata = wd; rdy_set = set;
    predict(v, tk, ep, pid, ok);
    if (we) m_cfg[wep] = wd;
    m_rdy = (m_rdy | set) & 16'hfeff;
    @(negedge clk);
    chk("R11", "rsp_valid", rsp_valid, v);
    if (v) begin
      chk(e_tag, "code", rsp_code, e_code);
      chk(e_tag, "buf", rsp_buf, e_buf);
      chk("R9", "addr", rsp_addr, e_addr);
      chk(e_tag, "done", done, e_done);
      chk(e_tag, "tog_flip", tog_flip, e_tf);
      chk(e_tag, "bsel_flip", bsel_flip, e_bf);
    end
    chk("R12", "rdy", rdy, m_rdy);
    rd_ep = ep[2:0]; #1;
    chk(e_tag, "cfg_rd", rd_data, m_cfg[ep]);
    if (we) begin rd_ep = wep[2:0]; #1; chk("R12", "cfg_wr", rd_data, m_cfg[wep]); end
    req_valid = 0; cfg_we = 0; rdy_set = 0;
  endtask

  task automatic req(int tk, int ep, bit pid, bit ok);
    step(1, tk, ep, pid, ok, 0, 0, 0, 0);
  endtask

  task automatic wr(int ep, logic [31:0] w, logic [15:0] set);
    step(0, 0, 0, 0, 0, 1, ep, w, set);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 8; i++) m_cfg[i] = '0;
    m_rdy = '0;
    repeat (3) @(negedge clk);
    chk("R11", "reset rsp_valid", rsp_valid, 0);
    chk("R12", "reset rdy", rdy, 0);
    chk("R12", "reset done", done, 0);
    for (int i = 0; i < 8; i++) begin
      rd_ep = i[2:0]; #1; chk("R12", "reset cfg", rd_data, 0);
    end
    rst_ni = 1'b1;
    @(negedge clk);

    // ep1: OUT, size 2000 clamps to 512 -> 128 words, base 64
    wr(1, mk(1,0,0,0,0,0,2000,64), 16'h0202);
    wr(2, mk(0,0,0,0,0,0,64,0), 16'h0004);
    req(T_OUT, 2, 0, 1);                       // R1 disabled
    chk("R1", "disabled code", rsp_code, C_NONE);
    req(3, 1, 0, 1);                           // R1 reserved token
    req(T_OUT, 1, 1, 1);                       // R5 pid mismatch
    chk("R5", "rdy kept", rdy[1], 1);
    req(T_OUT, 1, 0, 1);                       // R4 buffer 0
    chk("R9", "buf0 addr", rsp_addr, 64);
    req(T_OUT, 1, 1, 1);                       // R4 buffer 1
    chk("R9", "buf1 addr clamp", rsp_addr, 192);
    req(T_OUT, 1, 0, 1);                       // R3 NAK
    chk("R3", "nak", rsp_code, C_NAK);
    req(T_OUT, 1, 0, 0);                       // R6 rx error
    wr(3, mk(1,1,1,0,0,0,64,500), 16'h0008);
    req(T_IN, 3, 0, 1);                        // R2
    chk("R2", "stall", rsp_code, C_STALL);
    wr(1, mk(1,0,0,0,0,0,64,64), 16'h0002);
    req(T_IN, 1, 0, 1);                        // R8 direction
    req(T_SETUP, 1, 0, 1);                     // R8 setup on user ep
    chk("R8", "setup stall", rsp_code, C_STALL);
    wr(0, mk(1,0,0,0,0,1,64,0), 16'h0001);
    req(T_SETUP, 0, 1, 1);                     // R7
    chk("R7", "ep0 buf", rsp_buf, 0);
    chk("R7", "ep0 done", done, 1);
    wr(0, m_cfg[0], 16'h0001);
    req(T_IN, 0, 0, 1);                        // R7 IN on ep0
    wr(4, mk(1,0,1,0,0,0,512,700), 16'h0010);
    req(T_IN, 4, 0, 0);                        // R6 no host ack
    chk("R6", "in no ack code", rsp_code, C_DATA);
    req(T_IN, 4, 0, 1);                        // R4 IN
    wr(5, mk(1,0,0,1,0,0,2047,300), 16'h0000);
    req(T_OUT, 5, 1, 1);                       // R10 not ready -> none
    wr(5, m_cfg[5], 16'h2020);
    req(T_OUT, 5, 1, 1);                       // R10 commit
    chk("R10", "iso tog kept", tog_flip, 0);
    req(T_OUT, 5, 0, 1);
    chk("R9", "iso buf1 addr", rsp_addr, 556);
    // R12 collisions: write and ready-set against same-cycle commit
    wr(6, mk(1,0,0,0,0,0,64,900), 16'h0040);
    step(1, T_OUT, 6, 0, 1, 1, 6, mk(1,0,0,0,1,1,32,20), 16'h0140);
    chk("R12", "set wins", rdy[6], 1);
    chk("R12", "bit8", rdy[8], 0);

    for (int n = 0; n < 4000; n++) begin
      bit we; int wep; logic [31:0] w; logic [15:0] set; int tk;
      we  = ($urandom % 8) == 0;
      wep = $urandom % 8;
      w   = mk(($urandom % 8) != 0, ($urandom % 16) == 0, $urandom % 2,
               ($urandom % 6) == 0, $urandom % 2, $urandom % 2,
               $urandom % 2048, $urandom % 2048);
      set = (($urandom % 3) == 0) ? 16'($urandom) : 16'h0;
      tk  = (($urandom % 16) == 0) ? 3 : ($urandom % 3);
      step(($urandom % 4) != 0, tk, $urandom % 8, $urandom % 2,
           ($urandom % 8) != 0, we, wep, w, set);
    end
    summary();
  end
endmodule